// File: doc/BRIEF.md
# Register-Driven JTAG Shift Engine

This block is a JTAG master controlled by a host through a plain write/read strobe interface. A write carries an operation code, a 4-bit length field and a 16-bit payload. A scan operation makes the engine produce TCK at one quarter of the system clock. It also drives TMS and TDI to move an instruction or data word of 1 to 16 bits, least significant bit first. The bits seen on TDO while shifting are collected in a capture register that the host can read back.

Data scans can be split across several commands. Each data command chooses on its own whether to walk the TAP from Run-Test/Idle into Shift-DR first, and whether to leave through Exit1-DR and Update-DR back to Idle afterwards. A register longer than 16 bits can therefore be shifted in pieces: the first piece uses the entry walk only, the middle pieces use neither walk, and the last piece uses the exit walk only. Two other commands are provided. One moves the TAP to Run-Test/Idle from any state. The other writes a target-select register with one bit per downstream device, which goes out on pins and can be read back.

Top module: `jtag_shift_engine`

## Requirements
- R1: A write is accepted only while `busy` is low. `busy` rises on the next clock and stays high for exactly 4 clocks per TCK period of the operation. A write arriving while `busy` is high has no effect on any output or on any readable register.
- R2: Each TCK period is two clocks low followed by two clocks high. TCK stays low whenever the engine is not busy.
- R3: A scan shifts `wr_len`+1 bits, so length 0 gives 1 bit and length 15 gives 16 bits. TDI carries `wr_data` bit 0 first, then bit 1, and so on.
- R4: Operation codes 0 to 3 are data scans. Bit 0 of the code adds the entry walk, which is TMS 1,0,0 for three TCK periods before the first data bit. Bit 1 of the code adds the exit walk. Without the exit walk, TMS is 0 on every data bit.
- R5: The exit walk drives TMS=1 on the last data bit, followed by two extra TCK periods with TMS 1 then 0.
- R6: Operation code 4 is an instruction scan. It drives TMS 1,1,0,0, then the instruction bits with TMS=1 on the last one, then TMS 1,0.
- R7: Operation code 5 drives five TCK periods with TMS=1 and then one with TMS=0. TDI stays 0, the payload is ignored, and the capture register is unchanged.
- R8: In a scan, TDO is sampled at the end of the first high clock of each TCK period. Bit i of the scan goes to bit i of the capture register. Bits above the scan length read as 0, and the register is cleared when a scan command (code 0 to 4) is accepted. With `rd_sel`=0, `rd_data` shows it.
- R9: Operation code 6 stores `wr_data` bits 6:0 in the target-select register without starting a scan. The register drives `tgt_sel` and is read with `rd_sel`=1, zero-extended. Operation code 7 does nothing.
- R10: TMS and TDI change only in the clock where TCK falls, or at the start and end of an operation.
- R11: After reset, `busy`, TCK, TMS, TDI, `tgt_sel` and both readable registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_op | input | 3 | Operation code |
| wr_len | input | 4 | Bit count minus one |
| wr_data | input | 16 | Shift payload or select value |
| rd_sel | input | 1 | 0: capture register, 1: target select |
| rd_data | output | 16 | Read data |
| busy | output | 1 | Operation in progress |
| tgt_sel | output | 7 | One bit per downstream device |
| tck | output | 1 | JTAG clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |

## Verification
A wrong step counter or state shows on TMS within one TCK period, which is four clocks. It also lengthens or shortens `busy`, so each cycle of the pins is compared against a behavioural step list. A capture error shows on `rd_data` in the clock after the sampling edge. The bench reads the capture register on alternate clocks during scans, so such an error appears within two clocks. The target's TDO follows a pseudo-random sequence that advances on every falling TCK, so both a bit-order error and a wrong sample edge change the captured word.

// File: rtl/jse_pkg.sv
package jse_pkg;
  typedef enum logic [2:0] {
    OP_DR_NONE   = 3'd0,
    OP_DR_HEAD   = 3'd1,
    OP_DR_TAIL   = 3'd2,
    OP_DR_BOTH   = 3'd3,
    OP_IR        = 3'd4,
    OP_TAP_RESET = 3'd5,
    OP_TGT_SEL   = 3'd6,
    OP_NOP       = 3'd7
  } jse_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HEAD,
    ST_SHIFT,
    ST_TAIL
  } jse_state_e;

  // TMS walks, bit 0 goes out first
  localparam logic [7:0] WALK_DR  = 8'b0000_0001;
  localparam logic [7:0] WALK_IR  = 8'b0000_0011;
  localparam logic [7:0] WALK_RST = 8'b0001_1111;
endpackage

// File: rtl/jse_tck_gen.sv
module jse_tck_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic tck,
  output logic step_end,
  output logic sample
);
  localparam int PER = 2 * HALF_CYC;
  localparam int PW  = (PER > 2) ? $clog2(PER) : 1;

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (start) begin
      phase_d = '0;
    end else if (active) begin
      if (phase_q == PW'(PER - 1)) begin
        phase_d = '0;
      end else begin
        phase_d = phase_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign tck      = active && (phase_q >= PW'(HALF_CYC));
  assign step_end = active && (phase_q == PW'(PER - 1));
  assign sample   = active && (phase_q == PW'(HALF_CYC));
endmodule

// File: rtl/jse_sequencer.sv
module jse_sequencer
  import jse_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  jse_op_e           op,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] data,
  input  logic              step_end,
  output logic              busy,
  output logic              tms,
  output logic              tdi,
  output logic              shift_on,
  output logic [LEN_W-1:0]  bit_idx
);
  localparam int CW = (LEN_W > 3) ? LEN_W : 3;

  jse_state_e        st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] data_q;
  logic              tail_q;
  logic              more_q;
  logic [7:0]        walk_q;
  logic [2:0]        wlast_q;

  logic [7:0] walk_n;
  logic [2:0] wlast_n;
  logic       head_n, tail_n, more_n;

  // operation decode
  always_comb begin
    walk_n  = WALK_DR;
    wlast_n = 3'd2;
    head_n  = 1'b0;
    tail_n  = 1'b0;
    more_n  = 1'b1;
    case (op)
      OP_DR_NONE, OP_DR_HEAD, OP_DR_TAIL, OP_DR_BOTH: begin
        head_n = op[0];
        tail_n = op[1];
      end
      OP_IR: begin
        walk_n  = WALK_IR;
        wlast_n = 3'd3;
        head_n  = 1'b1;
        tail_n  = 1'b1;
      end
      default: begin
        walk_n  = WALK_RST;
        wlast_n = 3'd5;
        head_n  = 1'b1;
        more_n  = 1'b0;
      end
    endcase
  end

  // next state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (start) begin
      st_d  = head_n ? ST_HEAD : ST_SHIFT;
      cnt_d = '0;
    end else if (step_end) begin
      case (st_q)
        ST_HEAD: begin
          if (cnt_q[2:0] == wlast_q) begin
            cnt_d = '0;
            st_d  = more_q ? ST_SHIFT : ST_IDLE;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_SHIFT: begin
          if (cnt_q[LEN_W-1:0] == len_q) begin
            cnt_d = '0;
            st_d  = tail_q ? ST_TAIL : ST_IDLE;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_TAIL: begin
          if (cnt_q[0]) begin
            cnt_d = '0;
            st_d  = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      tail_q  <= 1'b0;
      more_q  <= 1'b0;
      walk_q  <= '0;
      wlast_q <= '0;
      data_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (start) begin
        len_q   <= len;
        tail_q  <= tail_n;
        more_q  <= more_n;
        walk_q  <= walk_n;
        wlast_q <= wlast_n;
      end
      if (start && more_n) begin
        data_q <= data;
      end
    end
  end

  // pin values
  always_comb begin
    tms = 1'b0;
    tdi = 1'b0;
    case (st_q)
      ST_HEAD:  tms = walk_q[cnt_q[2:0]];
      ST_SHIFT: begin
        tms = tail_q && (cnt_q[LEN_W-1:0] == len_q);
        tdi = data_q[cnt_q[LEN_W-1:0]];
      end
      ST_TAIL:  tms = ~cnt_q[0];
      default: ;
    endcase
  end

  assign busy     = (st_q != ST_IDLE);
  assign shift_on = (st_q == ST_SHIFT);
  assign bit_idx  = cnt_q[LEN_W-1:0];
endmodule

// File: rtl/jse_capture.sv
module jse_capture #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [LEN_W-1:0]  idx,
  input  logic              tdo,
  output logic [DATA_W-1:0] cap
);
  logic [DATA_W-1:0] cap_q, cap_d;

  always_comb begin
    cap_d = cap_q;
    if (clear) begin
      cap_d = '0;
    end else if (sample) begin
      cap_d[idx] = tdo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else begin
      cap_q <= cap_d;
    end
  end

  assign cap = cap_q;
endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine
  import jse_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LEN_W    = $clog2(DATA_W),
  parameter int N_TGT    = 7,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_op,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [N_TGT-1:0]  tgt_sel,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign srst_n = rst_pipe[1];

  jse_op_e op;
  logic    accept, start_scan, clear_cap, sel_en;
  logic    step_end, sample, shift_on;
  logic [LEN_W-1:0]  bit_idx;
  logic [DATA_W-1:0] cap;
  logic [N_TGT-1:0]  sel_q, sel_d;

  assign op         = jse_op_e'(wr_op);
  assign accept     = wr_en && !busy;
  assign start_scan = accept && (wr_op <= 3'(OP_TAP_RESET));
  assign clear_cap  = accept && (wr_op <= 3'(OP_IR));
  assign sel_en     = accept && (op == OP_TGT_SEL);

  jse_tck_gen #(.HALF_CYC(HALF_CYC)) u_tck (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (start_scan),
    .active   (busy),
    .tck      (tck),
    .step_end (step_end),
    .sample   (sample)
  );

  jse_sequencer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (start_scan),
    .op       (op),
    .len      (wr_len),
    .data     (wr_data),
    .step_end (step_end),
    .busy     (busy),
    .tms      (tms),
    .tdi      (tdi),
    .shift_on (shift_on),
    .bit_idx  (bit_idx)
  );

  jse_capture #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cap (
    .clk    (clk),
    .rst_n  (srst_n),
    .clear  (clear_cap),
    .sample (sample && shift_on),
    .idx    (bit_idx),
    .tdo    (tdo),
    .cap    (cap)
  );

  // target select register
  always_comb begin
    sel_d = sel_q;
    if (sel_en) begin
      sel_d = wr_data[N_TGT-1:0];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign tgt_sel = sel_q;
  assign rd_data = rd_sel ? DATA_W'(sel_q) : cap;
endmodule

// File: rtl/jse_checker.sv
module jse_checker #(
  parameter int N_TGT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             tck,
  input logic             tms,
  input logic             tdi,
  input logic [N_TGT-1:0] tgt_sel
);
  a_r2_idle_tck_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  a_r2_high_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |=> tck);

  a_r2_low_two: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tck) && busy) |=> !tck);

  a_r10_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(tck)) |-> ($stable(tms) && $stable(tdi)));

  a_r1_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(tgt_sel));

  a_r11_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tms && !tdi));
endmodule

bind jtag_shift_engine jse_checker #(.N_TGT(N_TGT)) u_jse_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .tck     (tck),
  .tms     (tms),
  .tdi     (tdi),
  .tgt_sel (tgt_sel)
);

// File: tb/jtag_shift_engine_bench.sv
`timescale 1ns/1ps
module jtag_shift_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_op = '0;
  logic [3:0]  wr_len = '0;
  logic [15:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic        busy, tck, tms, tdi;
  logic        tdo = 1'b0;
  logic [6:0]  tgt_sel;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  jtag_shift_engine u_jtag_shift_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_len(wr_len),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy),
    .tgt_sel(tgt_sel), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  // behavioural reference: list of TCK periods, each {capture, tms, tdi}
  logic [2:0]  steps[$];
  bit          m_busy;
  int          m_ph;
  int          m_bit;
  logic [15:0] m_cap;
  logic [6:0]  m_sel;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_load(logic [2:0] op, logic [3:0] len, logic [15:0] data);
    bit hd, tl;
    hd = (op == 3'd4) || (op <= 3'd3 && op[0]);
    tl = (op == 3'd4) || (op <= 3'd3 && op[1]);
    if (op == 3'd5) begin
      for (int k = 0; k < 5; k++) steps.push_back(3'b010);
      steps.push_back(3'b000);
      return;
    end
    if (op == 3'd4) begin
      steps.push_back(3'b010); steps.push_back(3'b010);
      steps.push_back(3'b000); steps.push_back(3'b000);
    end else if (hd) begin
      steps.push_back(3'b010); steps.push_back(3'b000); steps.push_back(3'b000);
    end
    for (int i = 0; i <= int'(len); i++)
      steps.push_back({1'b1, tl && (i == int'(len)), data[i]});
    if (tl) begin
      steps.push_back(3'b010); steps.push_back(3'b000);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps.delete();
      m_busy = 0; m_ph = 0; m_bit = 0; m_cap = '0; m_sel = '0;
    end else if (m_busy) begin
      if (m_ph == 2 && steps[0][2]) begin
        m_cap[m_bit] = tdo;
        m_bit++;
      end
      if (m_ph == 3) begin
        void'(steps.pop_front());
        m_ph = 0;
        if (steps.size() == 0) m_busy = 0;
      end else begin
        m_ph++;
      end
    end else if (wr_en) begin
      if (wr_op <= 3'd5) begin
        m_load(wr_op, wr_len, wr_data);
        m_busy = 1; m_ph = 0; m_bit = 0;
        if (wr_op <= 3'd4) m_cap = '0;
      end else if (wr_op == 3'd6) begin
        m_sel = wr_data[6:0];
      end
    end
  end

  // target: TDO follows an LFSR stepped on each falling TCK
  logic [7:0] lfsr = 8'h5A;
  logic       tck_prev = 1'b0;
  always @(negedge clk) begin
    if (tck_prev && !tck) lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tck_prev = tck;
    tdo = lfsr[0];
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 busy", 16'(busy), 16'(m_busy));
      chk("R2 tck", 16'(tck), 16'(m_busy && m_ph >= 2));
      chk("R4/R5/R6/R7/R10 tms", 16'(tms), 16'(m_busy ? steps[0][1] : 1'b0));
      chk("R3/R10 tdi", 16'(tdi), 16'(m_busy ? steps[0][0] : 1'b0));
      chk("R9 tgt_sel", 16'(tgt_sel), 16'(m_sel));
      if (rd_sel) chk("R9 readback", rd_data, 16'(m_sel));
      else        chk("R8 capture", rd_data, m_cap);
      rd_sel = ~rd_sel;
    end
  end

  task automatic issue(logic [2:0] op, logic [3:0] len, logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_len = len; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // runs one operation and checks how long busy stays high
  task automatic run(string tag, logic [2:0] op, logic [3:0] len, logic [15:0] data,
                     int periods);
    int n;
    issue(op, len, data);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk(tag, 16'(n), 16'(4 * periods));
    repeat (2) @(negedge clk);
  endtask

  task automatic scenario();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 busy", 16'(busy), 16'h0);
    chk("R11 pins", {13'b0, tck, tms, tdi}, 16'h0);
    chk("R11 tgt_sel", 16'(tgt_sel), 16'h0);
    chk("R11 rd_data", rd_data, 16'h0);

    issue(3'd6, 4'd0, 16'h0004);
    @(negedge clk);
    chk("R9 select write", 16'(tgt_sel), 16'h0004);
    chk("R9 no scan", 16'(busy), 16'h0);

    run("R7 reset length", 3'd5, 4'd0, 16'hFFFF, 6);
    run("R6 ir length", 3'd4, 4'd9, 16'h03C8, 4 + 10 + 2);
    run("R4 head only length", 3'd1, 4'd15, 16'h1234, 3 + 16);
    run("R5 tail only length", 3'd2, 4'd15, 16'hABCD, 16 + 2);
    run("R3 one bit both", 3'd3, 4'd0, 16'h0001, 3 + 1 + 2);
    run("R3 plain byte", 3'd0, 4'd7, 16'h00A5, 8);
    run("R7 reset keeps capture", 3'd5, 4'd3, 16'h5555, 6);

    // command during a scan must be dropped
    issue(3'd4, 4'd4, 16'h001F);
    issue(3'd6, 4'd0, 16'h007F);
    issue(3'd0, 4'd2, 16'h0007);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R1 select ignored when busy", 16'(tgt_sel), 16'h0004);
    chk("R1 scan ignored when busy", 16'(busy), 16'h0);

    issue(3'd7, 4'd5, 16'hFFFF);
    @(negedge clk);
    chk("R9 nop", {8'b0, busy, tgt_sel}, 16'h0004);

    issue(3'd6, 4'd0, 16'h0041);
    @(negedge clk);
    chk("R9 select second", 16'(tgt_sel), 16'h0041);
    run("R8 full word", 3'd3, 4'd15, 16'hC3A5, 3 + 16 + 2);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      scenario();
      begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
      end
    join_any
    disable fork;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule